// File: doc/BRIEF.md
# SGI Per-Source Pending Tracker

This block holds the pending state of software-generated interrupts for a multi-core interrupt distributor. Each combination of SGI number, destination core and originating core owns one bit, so every core that has raised a given SGI toward a given destination stays recorded until that one request is consumed. The state changes through four paths: a send request, an acknowledge, a sequential multi-target clear, and a register-style write.

For each destination core the block presents a pending level, the lowest-numbered pending SGI, and the originating core to hand over when that SGI is taken. An acknowledge port reports the originating core for any interrupt ID and target, and it retires only that originator's bit. A register window shows and alters the same storage as 32-bit words. Each word carries four SGIs, one byte per SGI, one bit per originating core. The window is indexed by destination core.

Top module: `sgi_src_tracker`

## Requirements
- R1: A send request sets bit `snd_src` of entry (`snd_sgi`, t) for every destination t whose bit in `snd_tgt_mask` is 1. No other entry changes.
- R2: An acknowledge of an SGI ID whose entry (ID, `ack_tgt`) is non-empty clears only the lowest set originator bit of that entry. The other bits stay set, so the SGI stays pending while any remain.
- R3: `ack_src` is the index of the lowest set bit of entry (`ack_irq`, `ack_tgt`). It is 0 when `ack_irq` is 16 or more, or when the entry is empty.
- R4: An acknowledge with `ack_irq` of 16 or more changes no state.
- R5: `tgt_pend[t]` is 1 exactly when any bit is set for destination t. When it is 1, `tgt_sgi` for t is the lowest SGI with a non-empty entry, and `tgt_src` for t is the lowest set bit of that entry.
- R6: `reg_rdata` for core c and word w has, at bit 8*k+s, the state of SGI 4*w+k, destination c, originator s. Bits 8*k+s with s ≥ NUM_CPU read 0.
- R7: A write with `reg_kind`=0 sets every state bit whose data bit is 1. A write with `reg_kind`=1 clears every state bit whose data bit is 1. Data bits of 0 leave the state as it was.
- R8: A clear request accepted while `clr_busy` is 0 removes bit `clr_src` of SGI `clr_sgi` at every destination in `clr_tgt_mask`, one destination per cycle. `clr_busy` is high for exactly popcount(mask) cycles and then drops. A request made while busy is ignored. A mask of 0 never raises `clr_busy`.
- R9: When a send and any clear path hit the same bit in the same cycle, the bit ends set.
- R10: After reset every bit is clear, all `tgt_pend` are 0 and every register word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_vld | input | 1 | Send request strobe |
| snd_sgi | input | 4 | SGI number to send |
| snd_tgt_mask | input | 8 | Destination cores |
| snd_src | input | 3 | Originating core |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_irq | input | 10 | Interrupt ID being acknowledged |
| ack_tgt | input | 3 | Acknowledging core |
| ack_src | output | 3 | Originator presented for (ack_irq, ack_tgt) |
| clr_req | input | 1 | Multi-target clear request |
| clr_sgi | input | 4 | SGI to clear |
| clr_tgt_mask | input | 8 | Destinations to clear |
| clr_src | input | 3 | Originator bit to clear |
| clr_busy | output | 1 | Clear walk in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_kind | input | 1 | 0 = set-pending word, 1 = clear-pending word |
| reg_cpu | input | 3 | Destination core whose view is accessed |
| reg_word | input | 2 | Word index (four SGIs per word) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| tgt_pend | output | 8 | Per-destination pending level |
| tgt_sgi | output | 32 | Per-destination lowest pending SGI, 4 bits each |
| tgt_src | output | 24 | Per-destination originator, 3 bits each |

## Verification
On every cycle the assertions check four things. A send always lands at each masked destination. A lone acknowledge removes exactly one originator bit. The presented originator and SGI point at a bit that is really set. The clear walker loses exactly one destination per busy cycle and keeps its captured SGI and originator. Only the bench scenarios can show the rest. These are the full register layout across all cores and words, that zero data bits and out-of-range IDs leave the state alone, that a request during a walk is ignored, the exact busy length, and that a send beats a simultaneous clear.

// File: rtl/sgi_trk_pkg.sv
`timescale 1ns/1ps
package sgi_trk_pkg;
   localparam int MAX_CPU      = 8;
   localparam int SGI_PER_WORD = 4;
   localparam int BYTE_W       = 8;
   localparam int WORD_W       = SGI_PER_WORD * BYTE_W;
   localparam logic KIND_SET   = 1'b0;
   localparam logic KIND_CLR   = 1'b1;
endpackage

// File: rtl/sgi_low_enc.sv
`timescale 1ns/1ps
// Lowest-set-bit encoder: idx is 0 when vec is empty.
module sgi_low_enc #(
   parameter int W     = 8,
   parameter int IDX_W = 3
) (
   input  logic [W-1:0]     vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   if (W > (1 << IDX_W)) begin : g_bad_w
      $error("sgi_low_enc: IDX_W too narrow for W");
   end

   always_comb begin
      any = |vec;
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/sgi_clr_walker.sv
`timescale 1ns/1ps
// Walks a destination mask one core per cycle, lowest first; each bit visited once.
module sgi_clr_walker #(
   parameter int NUM_CPU = 8,
   parameter int SRC_W   = 3,
   parameter int SGI_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [NUM_CPU-1:0] req_mask,
   input  logic [SGI_W-1:0]   req_sgi,
   input  logic [SRC_W-1:0]   req_src,
   output logic               busy,
   output logic               hit_vld,
   output logic [SRC_W-1:0]   hit_tgt,
   output logic [SGI_W-1:0]   hit_sgi,
   output logic [SRC_W-1:0]   hit_src
);
   logic [NUM_CPU-1:0] rem_q;
   logic [SGI_W-1:0]   sgi_q;
   logic [SRC_W-1:0]   src_q;
   logic               rem_any;

   sgi_low_enc #(.W(NUM_CPU), .IDX_W(SRC_W)) u_pick (
      .vec(rem_q), .any(rem_any), .idx(hit_tgt));

   assign busy    = rem_any;
   assign hit_vld = rem_any;
   assign hit_sgi = sgi_q;
   assign hit_src = src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         sgi_q <= '0;
         src_q <= '0;
      end else if (req && !rem_any) begin
         rem_q <= req_mask;
         sgi_q <= req_sgi;
         src_q <= req_src;
      end else if (rem_any) begin
         rem_q <= rem_q & (rem_q - 1'b1);
      end
   end

   AST_WALK_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($countones(rem_q) + 1 == $countones($past(rem_q)))); // R8
   AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(sgi_q) && $stable(src_q))); // R8
   AST_WALK_HIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vld |-> (rem_q[hit_tgt] && ((rem_q & ((NUM_CPU'(1) << hit_tgt) - 1'b1)) == '0))); // R8
endmodule

// File: rtl/sgi_src_tracker.sv
`timescale 1ns/1ps
module sgi_src_tracker
   import sgi_trk_pkg::*;
#(
   parameter int NUM_CPU = 8,
   parameter int NUM_SGI = 16,
   parameter int IRQ_W   = 10,
   localparam int SRC_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int SGI_W   = $clog2(NUM_SGI),
   localparam int NWORDS  = NUM_SGI / SGI_PER_WORD,
   localparam int WADDR_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       snd_vld,
   input  logic [SGI_W-1:0]           snd_sgi,
   input  logic [NUM_CPU-1:0]         snd_tgt_mask,
   input  logic [SRC_W-1:0]           snd_src,
   input  logic                       ack_vld,
   input  logic [IRQ_W-1:0]           ack_irq,
   input  logic [SRC_W-1:0]           ack_tgt,
   output logic [SRC_W-1:0]           ack_src,
   input  logic                       clr_req,
   input  logic [SGI_W-1:0]           clr_sgi,
   input  logic [NUM_CPU-1:0]         clr_tgt_mask,
   input  logic [SRC_W-1:0]           clr_src,
   output logic                       clr_busy,
   input  logic                       reg_wr,
   input  logic                       reg_kind,
   input  logic [SRC_W-1:0]           reg_cpu,
   input  logic [WADDR_W-1:0]         reg_word,
   input  logic [WORD_W-1:0]          reg_wdata,
   output logic [WORD_W-1:0]          reg_rdata,
   output logic [NUM_CPU-1:0]         tgt_pend,
   output logic [NUM_CPU*SGI_W-1:0]   tgt_sgi,
   output logic [NUM_CPU*SRC_W-1:0]   tgt_src
);
   if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu
      $error("sgi_src_tracker: NUM_CPU out of range");
   end
   if (NUM_SGI < SGI_PER_WORD || (NUM_SGI % SGI_PER_WORD) != 0 || (1 << SGI_W) != NUM_SGI) begin : g_bad_sgi
      $error("sgi_src_tracker: NUM_SGI must be a power of two of at least one word");
   end
   if (IRQ_W <= SGI_W) begin : g_bad_irq
      $error("sgi_src_tracker: IRQ_W must exceed the SGI ID width");
   end

   logic [NUM_CPU-1:0] pend_q [NUM_SGI][NUM_CPU];
   logic [NUM_CPU-1:0] nxt    [NUM_SGI][NUM_CPU];

   function automatic logic [NUM_CPU-1:0] onehot(input logic [SRC_W-1:0] i);
      onehot = NUM_CPU'(1) << i;
   endfunction

   // Acknowledge lookup
   logic               ack_is_sgi, ack_tgt_ok, ack_any;
   logic [SGI_W-1:0]   ack_sgi;
   logic [NUM_CPU-1:0] ack_entry;

   assign ack_is_sgi = (ack_irq < IRQ_W'(NUM_SGI));
   assign ack_tgt_ok = (int'(ack_tgt) < NUM_CPU);
   assign ack_sgi    = ack_irq[SGI_W-1:0];
   assign ack_entry  = (ack_is_sgi && ack_tgt_ok) ? pend_q[ack_sgi][ack_tgt] : '0;

   sgi_low_enc #(.W(NUM_CPU), .IDX_W(SRC_W)) u_ack_enc (
      .vec(ack_entry), .any(ack_any), .idx(ack_src));

   // Multi-target clear walker
   logic             wk_hit;
   logic [SRC_W-1:0] wk_tgt, wk_src;
   logic [SGI_W-1:0] wk_sgi;

   sgi_clr_walker #(.NUM_CPU(NUM_CPU), .SRC_W(SRC_W), .SGI_W(SGI_W)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .req(clr_req), .req_mask(clr_tgt_mask), .req_sgi(clr_sgi), .req_src(clr_src),
      .busy(clr_busy), .hit_vld(wk_hit), .hit_tgt(wk_tgt), .hit_sgi(wk_sgi), .hit_src(wk_src));

   // Next state: clears first, sets last so a send always survives
   always_comb begin
      for (int g = 0; g < NUM_SGI; g++) begin
         for (int t = 0; t < NUM_CPU; t++) begin
            logic [NUM_CPU-1:0] set_v;
            logic [NUM_CPU-1:0] clr_v;
            set_v = '0;
            clr_v = '0;
            if (snd_vld && int'(snd_sgi) == g && snd_tgt_mask[t])
               set_v = set_v | onehot(snd_src);
            if (reg_wr && int'(reg_cpu) == t && int'(reg_word) == g / SGI_PER_WORD) begin
               if (reg_kind == KIND_SET)
                  set_v = set_v | reg_wdata[(g % SGI_PER_WORD)*BYTE_W +: NUM_CPU];
               else
                  clr_v = clr_v | reg_wdata[(g % SGI_PER_WORD)*BYTE_W +: NUM_CPU];
            end
            if (ack_vld && ack_any && int'(ack_sgi) == g && int'(ack_tgt) == t)
               clr_v = clr_v | onehot(ack_src);
            if (wk_hit && int'(wk_sgi) == g && int'(wk_tgt) == t)
               clr_v = clr_v | onehot(wk_src);
            nxt[g][t] = (pend_q[g][t] & ~clr_v) | set_v;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int g = 0; g < NUM_SGI; g++)
            for (int t = 0; t < NUM_CPU; t++)
               pend_q[g][t] <= '0;
      end else begin
         pend_q <= nxt;
      end
   end

   // Register window
   always_comb begin
      reg_rdata = '0;
      if (int'(reg_cpu) < NUM_CPU) begin
         for (int k = 0; k < SGI_PER_WORD; k++)
            reg_rdata[k*BYTE_W +: NUM_CPU] = pend_q[int'(reg_word)*SGI_PER_WORD + k][reg_cpu];
      end
   end

   // Per-destination presentation
   for (genvar t = 0; t < NUM_CPU; t++) begin : g_tgt
      logic [NUM_SGI-1:0] sgi_vec;
      logic [NUM_CPU-1:0] ent;
      logic               any_s, any_e;
      logic [SGI_W-1:0]   s_idx;
      logic [SRC_W-1:0]   e_idx;

      always_comb begin
         for (int g = 0; g < NUM_SGI; g++) sgi_vec[g] = |pend_q[g][t];
      end

      sgi_low_enc #(.W(NUM_SGI), .IDX_W(SGI_W)) u_sgi_enc (
         .vec(sgi_vec), .any(any_s), .idx(s_idx));
      assign ent = pend_q[s_idx][t];
      sgi_low_enc #(.W(NUM_CPU), .IDX_W(SRC_W)) u_src_enc (
         .vec(ent), .any(any_e), .idx(e_idx));

      assign tgt_pend[t]                 = any_s;
      assign tgt_sgi[t*SGI_W +: SGI_W]   = s_idx;
      assign tgt_src[t*SRC_W +: SRC_W]   = e_idx;

      AST_PEND_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
         any_s |-> (any_e && pend_q[s_idx][t][e_idx])); // R5
      AST_SEND_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         (snd_vld && snd_tgt_mask[t]) |=> pend_q[$past(snd_sgi)][t][$past(snd_src)]); // R9
   end

   AST_ACK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld && ack_any && !snd_vld && !reg_wr && !clr_busy) |=>
      ($countones(pend_q[$past(ack_sgi)][$past(ack_tgt)]) + 1 == $countones($past(ack_entry)))); // R2
   AST_ACK_SRC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ack_any |-> (ack_entry[ack_src] && ((ack_entry & (onehot(ack_src) - 1'b1)) == '0))); // R3
   AST_NON_SGI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_is_sgi |-> (ack_src == '0)); // R4
endmodule

// File: tb/sgi_src_tracker_test.sv
`timescale 1ns/1ps
module sgi_src_tracker_test;
   localparam int NC = 8, NS = 16, IW = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic snd_vld = 0; logic [3:0] snd_sgi = 0; logic [7:0] snd_tgt_mask = 0; logic [2:0] snd_src = 0;
   logic ack_vld = 0; logic [IW-1:0] ack_irq = 0; logic [2:0] ack_tgt = 0; logic [2:0] ack_src;
   logic clr_req = 0; logic [3:0] clr_sgi = 0; logic [7:0] clr_tgt_mask = 0; logic [2:0] clr_src = 0;
   logic clr_busy;
   logic reg_wr = 0, reg_kind = 0; logic [2:0] reg_cpu = 0; logic [1:0] reg_word = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic [7:0] tgt_pend; logic [31:0] tgt_sgi; logic [23:0] tgt_src;

   sgi_src_tracker uut (.*);

   always #2.5 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit ended = 0;
   logic [7:0] m [NS][NC];

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int low(logic [7:0] v);
      for (int i = 7; i >= 0; i--) if (v[i]) low = i;
      if (v == 0) low = 0;
   endfunction

   task automatic compare_all(string req);
      for (int t = 0; t < NC; t++) begin
         bit p = 0; int es = 0;
         for (int g = NS - 1; g >= 0; g--) if (m[g][t] != 0) begin p = 1; es = g; end
         chk(tgt_pend[t] == p, {req, " R5 pend"}, tgt_pend[t], p);
         if (p) begin
            chk(tgt_sgi[t*4 +: 4] == es[3:0], {req, " R5 sgi"}, tgt_sgi[t*4 +: 4], es);
            chk(tgt_src[t*3 +: 3] == low(m[es][t]), {req, " R5 src"}, tgt_src[t*3 +: 3], low(m[es][t]));
         end
      end
      for (int c = 0; c < NC; c++)
         for (int w = 0; w < 4; w++) begin
            logic [31:0] e;
            reg_cpu = c[2:0]; reg_word = w[1:0];
            #0.1;
            e = {m[4*w+3][c], m[4*w+2][c], m[4*w+1][c], m[4*w][c]};
            chk(reg_rdata == e, {req, " R6 word"}, reg_rdata, e);
         end
   endtask

   task automatic send(int g, logic [7:0] mask, int s);
      snd_sgi = g[3:0]; snd_tgt_mask = mask; snd_src = s[2:0]; snd_vld = 1;
      @(posedge clk); #1; snd_vld = 0;
      for (int t = 0; t < NC; t++) if (mask[t]) m[g][t][s] = 1'b1;
   endtask

   task automatic ack(int irq, int t);
      ack_irq = irq[IW-1:0]; ack_tgt = t[2:0]; ack_vld = 1;
      @(posedge clk); #1; ack_vld = 0;
      if (irq < NS && m[irq][t] != 0) m[irq][t][low(m[irq][t])] = 1'b0;
   endtask

   task automatic regw(bit kind, int c, int w, logic [31:0] d);
      reg_kind = kind; reg_cpu = c[2:0]; reg_word = w[1:0]; reg_wdata = d; reg_wr = 1;
      @(posedge clk); #1; reg_wr = 0;
      for (int k = 0; k < 4; k++)
         if (kind) m[4*w+k][c] = m[4*w+k][c] & ~d[k*8 +: 8];
         else      m[4*w+k][c] = m[4*w+k][c] |  d[k*8 +: 8];
   endtask

   task automatic clear_all();
      for (int c = 0; c < NC; c++) for (int w = 0; w < 4; w++) regw(1, c, w, 32'hFFFF_FFFF);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #1000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int cnt;
      for (int g = 0; g < NS; g++) for (int t = 0; t < NC; t++) m[g][t] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      compare_all("R10 reset");

      // R1: sends to varied masks and sources
      for (int g = 0; g < NS; g++) begin
         logic [7:0] mk = 8'hA5;
         mk = (mk << (g % 8)) | (mk >> (8 - g % 8));
         send(g, mk, (g * 5) % 8);
         compare_all("R1 send");
      end
      send(3, 8'hFF, 7);
      compare_all("R1 all targets");

      // R7: clear through the register window
      clear_all();
      compare_all("R7 clear all");

      // R3/R2: lowest originator presented, only it retired
      send(5, 8'h04, 6);
      send(5, 8'h04, 3);
      ack_irq = 5; ack_tgt = 2; #0.1;
      chk(ack_src == 3, "R3 lowest source", ack_src, 3);
      ack(5, 2);
      compare_all("R2 one bit");
      ack_irq = 5; ack_tgt = 2; #0.1;
      chk(ack_src == 6, "R3 next source", ack_src, 6);
      chk(tgt_pend[2] == 1, "R2 still pending", tgt_pend[2], 1);
      ack(5, 2);
      compare_all("R2 drained");

      // R2/R3: exhaustive acknowledge sweep
      for (int g = 0; g < NS; g++) begin
         send(g, 8'hFF, (g * 3) % 8);
         send(g, 8'hFF, (g + 5) % 8);
      end
      compare_all("R1 fill");
      for (int g = 0; g < NS; g++)
         for (int t = 0; t < NC; t++)
            while (m[g][t] != 0) begin
               ack_irq = g[IW-1:0]; ack_tgt = t[2:0]; #0.1;
               chk(ack_src == low(m[g][t]), "R3 sweep source", ack_src, low(m[g][t]));
               ack(g, t);
            end
      compare_all("R2 sweep");
      ack_irq = 7; ack_tgt = 1; #0.1;
      chk(ack_src == 0, "R3 empty entry", ack_src, 0);

      // R3/R4: IDs beyond the SGI range
      send(0, 8'hFF, 5);
      ack_irq = 16; ack_tgt = 0; #0.1;
      chk(ack_src == 0, "R3 id16 source", ack_src, 0);
      ack(16, 0);
      ack(20, 3);
      ack(1023, 7);
      compare_all("R4 non-SGI ack");

      // R7: set/clear words, zero data bits inert
      clear_all();
      regw(0, 3, 1, 32'h8100_0201);
      compare_all("R7 set");
      regw(0, 3, 1, 32'h0);
      compare_all("R7 set zero");
      regw(1, 3, 1, 32'h0);
      compare_all("R7 clear zero");
      regw(1, 3, 1, 32'h0000_0001);
      compare_all("R7 clear bit");
      regw(0, 7, 3, 32'hFFFF_FFFF);
      compare_all("R7 full word");

      // R8: walker
      clear_all();
      send(9, 8'hFF, 4);
      send(9, 8'hFF, 1);
      clr_sgi = 9; clr_tgt_mask = 8'b1011_0010; clr_src = 4; clr_req = 1;
      @(posedge clk); #1; clr_req = 0;
      cnt = 0;
      while (clr_busy && cnt < 100) begin cnt++; @(posedge clk); #1; end
      chk(cnt == 4, "R8 busy length", cnt, 4);
      for (int t = 0; t < NC; t++) if (t == 1 || t == 4 || t == 5 || t == 7) m[9][t][4] = 0;
      compare_all("R8 walk result");

      clr_sgi = 9; clr_tgt_mask = 8'h0F; clr_src = 1; clr_req = 1;
      @(posedge clk); #1;
      clr_tgt_mask = 8'hF0; clr_src = 4;
      @(posedge clk); #1; clr_req = 0;
      cnt = 1;
      while (clr_busy && cnt < 100) begin cnt++; @(posedge clk); #1; end
      chk(cnt == 4, "R8 busy ignore", cnt, 4);
      for (int t = 0; t < 4; t++) m[9][t][1] = 0;
      compare_all("R8 busy request ignored");

      clr_sgi = 9; clr_tgt_mask = 8'h00; clr_src = 1; clr_req = 1;
      @(posedge clk); #1; clr_req = 0;
      chk(clr_busy == 0, "R8 empty mask", clr_busy, 0);
      compare_all("R8 empty mask state");

      // R9: send beats a same-cycle clear
      clear_all();
      send(2, 8'h02, 0);
      ack_irq = 2; ack_tgt = 1; ack_vld = 1;
      snd_sgi = 2; snd_tgt_mask = 8'h02; snd_src = 0; snd_vld = 1;
      @(posedge clk); #1; ack_vld = 0; snd_vld = 0;
      compare_all("R9 send vs ack");
      reg_kind = 1; reg_cpu = 1; reg_word = 0; reg_wdata = 32'h0000_0100; reg_wr = 1;
      snd_sgi = 1; snd_tgt_mask = 8'h02; snd_src = 0; snd_vld = 1;
      @(posedge clk); #1; reg_wr = 0; snd_vld = 0;
      m[1][1][0] = 1;
      compare_all("R9 send vs reg clear");
      clr_sgi = 4; clr_tgt_mask = 8'h01; clr_src = 2; clr_req = 1;
      @(posedge clk); #1; clr_req = 0;
      snd_sgi = 4; snd_tgt_mask = 8'h01; snd_src = 2; snd_vld = 1;
      @(posedge clk); #1; snd_vld = 0;
      m[4][0][2] = 1;
      chk(clr_busy == 0, "R9 walker done", clr_busy, 0);
      compare_all("R9 send vs walker");

      finish_run();
   end
endmodule